// File: doc/BRIEF.md
# Power and RMS Computation Engine

The engine takes a stream of signed instantaneous voltage and current samples, one pair per output-word period. It integrates the squared voltage, the squared current and their product over a computation cycle of N samples. When the cycle closes, it turns those three sums into RMS voltage, RMS current, active power and apparent power. All four results appear together, and a one-clock ready pulse marks each update. Samples and signed results are 24-bit two's-complement fractions (Q1.23, range -1 to just below +1). RMS values and apparent power are unsigned fractions in the same scale.

A built-in timer divides the system clock by a programmable factor K and then by a fixed word divider. The result is the output-word tick that paces the upstream sample source. Post-processing runs on a snapshot of the sums: three sequential dividers, then two sequential square-root units, then one multiply. Accumulation of the next cycle therefore continues while the previous cycle's results are still being formed. The sample period must exceed the post-processing latency.

Top module: `pwr_rms_engine`

## Requirements
- R1: `owr_tick` is a one-clock pulse repeating every K*WORD_DIV clocks, where K is `clk_div_k` and a K of 0 acts as 1.
- R2: The cycle length N is taken from `cycle_count` on the clock edge that accepts the first sample of a cycle; a value of 0 acts as 1; changes made later in the cycle have no effect until the next cycle begins.
- R3: Every cycle's sums cover only that cycle's samples (the accumulators restart at each cycle), and the sums are wide enough for N up to 65535 full-scale samples without overflow.
- R4: `v_rms` equals floor(sqrt(trunc(sum(v*v)/N))) on the Q1.23 integer codes, saturated to 0x7FFFFF; `i_rms` is formed the same way from current.
- R5: `p_active` equals floor(trunc(sum(v*i)/N) / 2^23), with the division truncating toward zero and the result saturated to the range 0x800000..0x7FFFFF (two's complement).
- R6: `s_apparent` equals floor(v_rms * i_rms / 2^23) using the saturated RMS values.
- R7: All four results change only together, on the cycle `result_ready` is high; `result_ready` is high for exactly one clock per computation cycle, and the results hold their values otherwise.
- R8: After reset all results are 0 and `result_ready` is low.
- R9: `result_ready` is high in the 75th clock after the edge that accepted a cycle's last sample (default widths).

Top module port list order is given below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div_k | input | DIV_W | Clock divider K for the word timer |
| owr_tick | output | 1 | Output-word-rate pulse |
| sample_vld | input | 1 | Sample pair valid strobe |
| v_sample | input | SAMPLE_W | Signed Q1.23 instantaneous voltage |
| i_sample | input | SAMPLE_W | Signed Q1.23 instantaneous current |
| cycle_count | input | CNT_W | Samples per computation cycle (N) |
| v_rms | output | SAMPLE_W | Unsigned RMS voltage |
| i_rms | output | SAMPLE_W | Unsigned RMS current |
| p_active | output | SAMPLE_W | Signed active power |
| s_apparent | output | SAMPLE_W | Unsigned apparent power |
| result_ready | output | 1 | One-clock pulse when results update |

## Verification
Two things can fall into the same clock. The accepting edge of a cycle's first sample can coincide with a new `cycle_count` value. Separately, the closing of one cycle's sums overlaps the start of the next cycle's accumulation. The bench drives a new `cycle_count` on the same cycle it presents a first sample, and it expects the new N to govern that cycle. It also changes `cycle_count` in the middle of a cycle and expects no effect. A directed cycle of large values is followed immediately by a cycle of zeros; zero results show that the restart dropped the old sums. The results of all these cycles are judged against bench-computed sums, roots and products.

// File: rtl/pwr_rms_pkg.sv
// Shared types for the power and RMS computation engine.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_rms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_ROOT,
        ST_MUL
    } post_state_e;
endpackage

// File: rtl/owr_timer.sv
// Output-word-rate timer: divides clk by K, then by WORD_DIV, and emits a
// one-clock tick at the end of each word period.
// Assumes: WORD_DIV >= 2 and is a power of two.
module owr_timer #(
    parameter int DIV_W    = 8,
    parameter int WORD_DIV = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clk_div_k,
    output logic             tick
);
    localparam int WCNT_W = $clog2(WORD_DIV);

    logic [DIV_W-1:0]  k_cnt;
    logic [WCNT_W-1:0] w_cnt;
    logic [DIV_W-1:0]  k_lim;

    // last prescaler count; K of zero behaves as one
    assign k_lim = (clk_div_k == '0) ? '0 : clk_div_k - DIV_W'(1);

    // prescaler, word counter and tick generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_cnt <= '0;
            w_cnt <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (k_cnt >= k_lim) begin
                k_cnt <= '0;
                if (w_cnt == WCNT_W'(WORD_DIV - 1)) begin
                    w_cnt <= '0;
                    tick  <= 1'b1;
                end else begin
                    w_cnt <= w_cnt + WCNT_W'(1);
                end
            end else begin
                k_cnt <= k_cnt + DIV_W'(1);
            end
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cycle_accum.sv
// Per-cycle accumulator: sums v*v, i*i and v*i over N samples, takes N
// at the first sample of a cycle, and publishes the three sums with a
// one-clock close pulse on the last sample.
// Assumes: samples are two's-complement; ACC_W >= 2*SAMPLE_W + CNT_W.
module cycle_accum #(
    parameter int SAMPLE_W   = 24,
    parameter int CNT_W      = 16,
    parameter int ACC_W      = 64,
    parameter int DEF_CYCLES = 4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_vld,
    input  logic signed [SAMPLE_W-1:0] v_in,
    input  logic signed [SAMPLE_W-1:0] i_in,
    input  logic [CNT_W-1:0]           cycle_count,
    output logic                       close_pulse,
    output logic [ACC_W-1:0]           sum_vv,
    output logic [ACC_W-1:0]           sum_ii,
    output logic signed [ACC_W-1:0]    sum_vi,
    output logic [CNT_W-1:0]           n_used
);
    localparam int PROD_W = 2 * SAMPLE_W;

    logic signed [PROD_W-1:0] p_vv, p_ii, p_vi;
    logic signed [ACC_W-1:0]  t_vv, t_ii, t_vi;
    logic signed [ACC_W-1:0]  acc_vv, acc_ii, acc_vi;
    logic signed [ACC_W-1:0]  nx_vv, nx_ii, nx_vi;
    logic [CNT_W-1:0]         smp_cnt, act_n, n_req, n_eff;
    logic                     first, last;

    // instantaneous squares and product, sign-extended to sum width
    assign p_vv = v_in * v_in;
    assign p_ii = i_in * i_in;
    assign p_vi = v_in * i_in;
    assign t_vv = {{(ACC_W-PROD_W){p_vv[PROD_W-1]}}, p_vv};
    assign t_ii = {{(ACC_W-PROD_W){p_ii[PROD_W-1]}}, p_ii};
    assign t_vi = {{(ACC_W-PROD_W){p_vi[PROD_W-1]}}, p_vi};

    // cycle length selection and boundary detection
    assign n_req = (cycle_count == '0) ? CNT_W'(1) : cycle_count;
    assign first = (smp_cnt == '0);
    assign n_eff = first ? n_req : act_n;
    assign last  = (smp_cnt == n_eff - CNT_W'(1));

    // running sums restart from zero on a cycle's first sample
    assign nx_vv = (first ? '0 : acc_vv) + t_vv;
    assign nx_ii = (first ? '0 : acc_ii) + t_ii;
    assign nx_vi = (first ? '0 : acc_vi) + t_vi;

    // accumulate samples, close the cycle and publish the sums
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_vv      <= '0;
            acc_ii      <= '0;
            acc_vi      <= '0;
            smp_cnt     <= '0;
            act_n       <= CNT_W'(DEF_CYCLES);
            close_pulse <= 1'b0;
            sum_vv      <= '0;
            sum_ii      <= '0;
            sum_vi      <= '0;
            n_used      <= CNT_W'(DEF_CYCLES);
        end else begin
            close_pulse <= 1'b0;
            if (sample_vld) begin
                if (first) begin
                    act_n <= n_req;
                end
                if (last) begin
                    sum_vv      <= nx_vv;
                    sum_ii      <= nx_ii;
                    sum_vi      <= nx_vi;
                    n_used      <= n_eff;
                    close_pulse <= 1'b1;
                    smp_cnt     <= '0;
                    acc_vv      <= '0;
                    acc_ii      <= '0;
                    acc_vi      <= '0;
                end else begin
                    acc_vv  <= nx_vv;
                    acc_ii  <= nx_ii;
                    acc_vi  <= nx_vi;
                    smp_cnt <= smp_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R2
    smp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_cnt != '0) |-> (smp_cnt < act_n));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vv[ACC_W-1] && !acc_ii[ACC_W-1]);
endmodule

// File: rtl/seq_divider.sv
// Sequential restoring divider: one quotient bit per clock, Q_W clocks.
// Assumes: the quotient fits in Q_W bits (num < den * 2^Q_W) and den != 0.
module seq_divider #(
    parameter int NUM_W = 64,
    parameter int DEN_W = 16,
    parameter int Q_W   = 47
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo
);
    localparam int CNT_W = $clog2(Q_W + 1);

    logic [DEN_W-1:0] rem, den_q;
    logic [Q_W-1:0]   low;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;
    logic [NUM_W-1:0] high;

    assign high  = num >> Q_W;
    assign trial = {rem, low[Q_W-1]};

    // load operands, then shift-subtract one bit per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            low   <= '0;
            quo   <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= high[DEN_W-1:0];
                den_q <= den;
                low   <= num[Q_W-1:0];
                quo   <= '0;
                cnt   <= CNT_W'(Q_W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= DEN_W'(trial - {1'b0, den_q});
                    quo <= {quo[Q_W-2:0], 1'b1};
                end else begin
                    rem <= trial[DEN_W-1:0];
                    quo <= {quo[Q_W-2:0], 1'b0};
                end
                low <= low << 1;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R4
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem < den_q));
endmodule

// File: rtl/seq_sqrt.sv
// Sequential integer square root, two radicand bits per clock,
// RAD_W/2 clocks; the root is floor(sqrt(radicand)).
// Assumes: RAD_W is even.
module seq_sqrt #(
    parameter int RAD_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RAD_W-1:0]   rad_in,
    output logic               done,
    output logic [RAD_W/2-1:0] root
);
    localparam int ROOT_W = RAD_W / 2;
    localparam int CNT_W  = $clog2(ROOT_W + 1);

    logic [RAD_W-1:0]  rad;
    logic [ROOT_W:0]   rem;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    logic [ROOT_W+2:0] r4, trial;

    assign r4    = {rem, rad[RAD_W-1:RAD_W-2]};
    assign trial = {1'b0, root, 2'b01};

    // load radicand, then settle one root bit per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad  <= '0;
            rem  <= '0;
            root <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rad  <= rad_in;
                rem  <= '0;
                root <= '0;
                cnt  <= CNT_W'(ROOT_W);
                busy <= 1'b1;
            end else if (busy) begin
                if (r4 >= trial) begin
                    rem  <= (ROOT_W+1)'(r4 - trial);
                    root <= {root[ROOT_W-2:0], 1'b1};
                end else begin
                    rem  <= r4[ROOT_W:0];
                    root <= {root[ROOT_W-2:0], 1'b0};
                end
                rad <= rad << 2;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R4
    root_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem <= {root, 1'b0}));
endmodule

// File: rtl/pwr_rms_engine.sv
// Power and RMS computation engine top: word timer, per-cycle
// accumulation, then divide -> square root -> multiply post-processing
// with an atomic result update and one-clock ready pulse.
// Assumes: samples arrive further apart than the post-processing latency.
module pwr_rms_engine #(
    parameter int SAMPLE_W   = 24,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8,
    parameter int WORD_DIV   = 1024,
    parameter int DEF_CYCLES = 4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DIV_W-1:0]           clk_div_k,
    output logic                       owr_tick,
    input  logic                       sample_vld,
    input  logic signed [SAMPLE_W-1:0] v_sample,
    input  logic signed [SAMPLE_W-1:0] i_sample,
    input  logic [CNT_W-1:0]           cycle_count,
    output logic [SAMPLE_W-1:0]        v_rms,
    output logic [SAMPLE_W-1:0]        i_rms,
    output logic signed [SAMPLE_W-1:0] p_active,
    output logic [SAMPLE_W-1:0]        s_apparent,
    output logic                       result_ready
);
    import pwr_rms_pkg::*;

    localparam int PROD_W = 2 * SAMPLE_W;
    localparam int ACC_W  = PROD_W + CNT_W;
    localparam int Q_W    = PROD_W - 1;
    localparam int FRAC   = SAMPLE_W - 1;
    localparam int N_DIV  = 3;
    localparam int N_ROOT = 2;
    localparam logic signed [Q_W:0] P_MAX = (Q_W+1)'((1 << FRAC) - 1);
    localparam logic signed [Q_W:0] P_MIN = -P_MAX - 1;
    localparam logic [SAMPLE_W-1:0] U_MAX = SAMPLE_W'((1 << FRAC) - 1);

    post_state_e st;

    logic                    close_pulse;
    logic [ACC_W-1:0]        sum_vv, sum_ii, vi_abs;
    logic signed [ACC_W-1:0] sum_vi;
    logic [CNT_W-1:0]        n_used;
    logic                    vi_neg;
    logic                    div_go, root_go;
    logic [ACC_W-1:0]        div_num  [N_DIV];
    logic [Q_W-1:0]          div_quo  [N_DIV];
    logic                    div_done [N_DIV];
    logic [PROD_W-1:0]       root_rad [N_ROOT];
    logic [SAMPLE_W-1:0]     root_val [N_ROOT];
    logic                    root_done[N_ROOT];
    logic signed [Q_W:0]     p_mean, p_sh;
    logic [SAMPLE_W-1:0]     p_hold, vr_hold, ir_hold;
    logic [PROD_W-1:0]       s_prod;

    owr_timer #(.DIV_W(DIV_W), .WORD_DIV(WORD_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .clk_div_k(clk_div_k), .tick(owr_tick)
    );

    cycle_accum #(
        .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .ACC_W(ACC_W),
        .DEF_CYCLES(DEF_CYCLES)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .v_in(v_sample), .i_in(i_sample), .cycle_count(cycle_count),
        .close_pulse(close_pulse), .sum_vv(sum_vv), .sum_ii(sum_ii),
        .sum_vi(sum_vi), .n_used(n_used)
    );

    // magnitudes fed to the three mean dividers
    assign vi_abs     = sum_vi[ACC_W-1] ? ACC_W'(-sum_vi) : sum_vi;
    assign div_num[0] = sum_vv;
    assign div_num[1] = sum_ii;
    assign div_num[2] = vi_abs;
    assign div_go     = close_pulse && (st == ST_IDLE);

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        seq_divider #(.NUM_W(ACC_W), .DEN_W(CNT_W), .Q_W(Q_W)) u_div (
            .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num[g]),
            .den(n_used), .done(div_done[g]), .quo(div_quo[g])
        );
    end

    // mean squares zero-extended to an even radicand width
    assign root_go = (st == ST_DIV) && div_done[0];

    for (genvar g = 0; g < N_ROOT; g++) begin : g_root
        assign root_rad[g] = {1'b0, div_quo[g]};
        seq_sqrt #(.RAD_W(PROD_W)) u_root (
            .clk(clk), .rst_n(rst_n), .start(root_go), .rad_in(root_rad[g]),
            .done(root_done[g]), .root(root_val[g])
        );
    end

    // signed mean product scaled back to Q1.23 (floor)
    assign p_mean = vi_neg ? -$signed({1'b0, div_quo[2]})
                           : $signed({1'b0, div_quo[2]});
    assign p_sh   = p_mean >>> FRAC;
    assign s_prod = vr_hold * ir_hold;

    // post-processing sequencer and atomic result update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            vi_neg       <= 1'b0;
            p_hold       <= '0;
            vr_hold      <= '0;
            ir_hold      <= '0;
            v_rms        <= '0;
            i_rms        <= '0;
            p_active     <= '0;
            s_apparent   <= '0;
            result_ready <= 1'b0;
        end else begin
            result_ready <= 1'b0;
            case (st)
                ST_IDLE: if (div_go) begin
                    vi_neg <= sum_vi[ACC_W-1];
                    st     <= ST_DIV;
                end
                ST_DIV: if (div_done[0]) begin
                    if (p_sh > P_MAX)      p_hold <= P_MAX[SAMPLE_W-1:0];
                    else if (p_sh < P_MIN) p_hold <= P_MIN[SAMPLE_W-1:0];
                    else                   p_hold <= p_sh[SAMPLE_W-1:0];
                    st <= ST_ROOT;
                end
                ST_ROOT: if (root_done[0]) begin
                    vr_hold <= root_val[0][SAMPLE_W-1] ? U_MAX : root_val[0];
                    ir_hold <= root_val[1][SAMPLE_W-1] ? U_MAX : root_val[1];
                    st      <= ST_MUL;
                end
                ST_MUL: begin
                    v_rms        <= vr_hold;
                    i_rms        <= ir_hold;
                    p_active     <= p_hold;
                    s_apparent   <= s_prod[FRAC +: SAMPLE_W];
                    result_ready <= 1'b1;
                    st           <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R9
    post_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_pulse |-> (st == ST_IDLE));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_ready |=> !result_ready);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_ready |-> ($stable(v_rms) && $stable(p_active)));
endmodule

// File: tb/test_pwr_rms_engine.sv
`timescale 1ns/1ps
module test_pwr_rms_engine;
    localparam int SW = 24;
    localparam int WD = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        clk_div_k = 8'd1;
    logic              owr_tick;
    logic              sample_vld = 1'b0;
    logic signed [SW-1:0] v_sample = '0, i_sample = '0;
    logic [15:0]       cycle_count = 16'd1;
    logic [SW-1:0]     v_rms, i_rms, s_apparent;
    logic signed [SW-1:0] p_active;
    logic              result_ready;

    int checks = 0, failures = 0;
    longint cyc = 0;

    pwr_rms_engine #(.WORD_DIV(WD)) i_pwr_rms_engine (
        .clk(clk), .rst_n(rst_n), .clk_div_k(clk_div_k), .owr_tick(owr_tick),
        .sample_vld(sample_vld), .v_sample(v_sample), .i_sample(i_sample),
        .cycle_count(cycle_count), .v_rms(v_rms), .i_rms(i_rms),
        .p_active(p_active), .s_apparent(s_apparent),
        .result_ready(result_ready)
    );

    always #2.5 clk = ~clk;

    // model state
    longint m_vv, m_ii, m_vi;
    int     m_n, m_cnt = 0;
    longint q_v[$], q_i[$], q_p[$], q_s[$], q_t[$];
    string  q_tag[$];
    int     hold_err = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic longint isqrt(input longint x);
        longint r = 0;
        for (int b = 23; b >= 0; b--) begin
            longint t = r | (longint'(1) << b);
            if (t * t <= x) r = t;
        end
        return r;
    endfunction

    function automatic longint usat(input longint x);
        return (x > 64'd8388607) ? 64'd8388607 : x;
    endfunction

    // cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    // drive one sample pair on the next word tick and update the model
    task automatic put(input logic signed [SW-1:0] v, input logic signed [SW-1:0] i,
                       input string tag);
        do @(negedge clk); while (owr_tick !== 1'b1);
        if (m_cnt == 0) begin
            m_n  = (cycle_count == 0) ? 1 : int'(cycle_count);
            m_vv = 0; m_ii = 0; m_vi = 0;
        end
        m_vv += longint'(v) * longint'(v);
        m_ii += longint'(i) * longint'(i);
        m_vi += longint'(v) * longint'(i);
        m_cnt++;
        v_sample = v; i_sample = i; sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        if (m_cnt == m_n) begin
            longint rv, ri, mq, pe;
            rv = usat(isqrt(m_vv / m_n));
            ri = usat(isqrt(m_ii / m_n));
            mq = ((m_vi < 0) ? -m_vi : m_vi) / m_n;
            if (m_vi < 0) mq = -mq;
            pe = mq >>> 23;
            if (pe > 8388607) pe = 8388607;
            if (pe < -8388608) pe = -8388608;
            q_v.push_back(rv); q_i.push_back(ri); q_p.push_back(pe);
            q_s.push_back((rv * ri) >>> 23);
            q_t.push_back(cyc); q_tag.push_back(tag);
            m_cnt = 0;
        end
    endtask

    // result monitor: compare each ready pulse with the model queue
    logic prev_rdy = 1'b0, seen = 1'b0;
    logic [SW-1:0] l_v, l_i, l_p, l_s;
    always @(negedge clk) begin
        if (rst_n) begin
            if (result_ready) begin
                if (prev_rdy) chk("R7 ready width", 2, 1);
                if (q_v.size() == 0) chk("R7 unexpected ready", 1, 0);
                else begin
                    string tg = q_tag.pop_front();
                    chk({"R4 v_rms ", tg}, longint'(v_rms), q_v.pop_front());
                    chk({"R4 i_rms ", tg}, longint'(i_rms), q_i.pop_front());
                    chk({"R5 p_active ", tg}, longint'(p_active), q_p.pop_front());
                    chk({"R6 s_apparent ", tg}, longint'(s_apparent), q_s.pop_front());
                    chk({"R9 latency ", tg}, cyc - q_t.pop_front(), 75);
                end
                seen = 1'b1;
            end else if (seen && ({v_rms, i_rms, p_active, s_apparent} != {l_v, l_i, l_p, l_s})) begin
                hold_err++;
            end
            prev_rdy = result_ready;
            l_v = v_rms; l_i = i_rms; l_p = p_active; l_s = s_apparent;
        end
    end

    task automatic drain();
        while (q_v.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic signed [SW-1:0] rnd_smp();
        int sel = $urandom_range(0, 9);
        if (sel == 0) return 24'sh800000;
        if (sel == 1) return 24'sh7FFFFF;
        return SW'($urandom);
    endfunction

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        // R8 reset state
        chk("R8 v_rms", longint'(v_rms), 0);
        chk("R8 p_active", longint'(p_active), 0);
        chk("R8 s_apparent", longint'(s_apparent), 0);
        chk("R8 ready", longint'(result_ready), 0);
        rst_n = 1'b1;

        // R4 R5 R6 full-scale negative inputs saturate
        cycle_count = 16'd1;
        put(24'sh800000, 24'sh800000, "fullscale");
        // R5 negative power over four samples
        cycle_count = 16'd4;
        for (int k = 0; k < 4; k++) put(24'sh400000, 24'shE00000, "negative");
        // R3 zero cycle right after a large one
        cycle_count = 16'd2;
        put(24'sh7FFFFF, 24'sh7FFFFF, "large");
        put(24'sh7FFFFF, 24'sh800000, "large");
        put(24'sh000000, 24'sh000000, "zero after large");
        put(24'sh000000, 24'sh000000, "zero after large");
        // R2 zero count acts as one
        cycle_count = 16'd0;
        put(24'sh123456, 24'sh654321, "count zero");
        // R2 mid-cycle change ignored
        cycle_count = 16'd3;
        put(24'sh200000, 24'sh300000, "mid change");
        cycle_count = 16'd5;
        put(24'sh100000, 24'shF00000, "mid change");
        put(24'sh050000, 24'sh0A0000, "mid change");
        // R2 new count coincides with the boundary sample (set before tick)
        cycle_count = 16'd2;
        put(24'sh3FFFFF, 24'shC00001, "boundary change");
        put(24'sh111111, 24'sh222222, "boundary change");
        drain();

        // random cycles
        for (int c = 0; c < 24; c++) begin
            cycle_count = 16'($urandom_range(1, 12));
            for (int k = 0; k < int'(cycle_count); k++)
                put(rnd_smp(), rnd_smp(), "random");
        end
        drain();
        chk("R7 results held between pulses", hold_err, 0);

        // R1 tick period with K=3 and K=0
        begin
            longint t0;
            clk_div_k = 8'd3;
            do @(negedge clk); while (owr_tick !== 1'b1);
            do @(negedge clk); while (owr_tick !== 1'b1);
            t0 = cyc;
            do @(negedge clk); while (owr_tick !== 1'b1);
            chk("R1 tick period K=3", cyc - t0, 3 * WD);
            clk_div_k = 8'd0;
            do @(negedge clk); while (owr_tick !== 1'b1);
            do @(negedge clk); while (owr_tick !== 1'b1);
            t0 = cyc;
            do @(negedge clk); while (owr_tick !== 1'b1);
            chk("R1 tick period K=0", cyc - t0, WD);
        end
        finish_run();
    end
endmodule